// File: doc/BRIEF.md
# One-Hot Jackpot Reaction Game

The block drives four lamps and watches four player switches. In play, a single lit lamp walks around the four positions, moving one place each time a clock prescaler reaches its terminal count. Each switch belongs to one lamp. A player who turns a switch on while its own lamp is lit wins the jackpot. The block then lights every lamp, raises a win flag and freezes there until reset.

The switch inputs are treated as asynchronous. They pass through a multi-stage synchronizer, and an edge detector then keeps only off-to-on transitions. A switch that is already on therefore never scores, and neither does a switch that is turned off. The prescaler's terminal count is a parameter. At the default it gives a step of roughly 100 ms from a 100 MHz clock, which is quick but still slow enough for the eye to follow.

Top module: `jackpot_game`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block leaves that edge with `led_out` = 4'b0001 (lamp 0 lit) and `win` = 0.
- R2: While `win` is 0, exactly one bit of `led_out` is set.
- R3: In play, the lit lamp advances on the TICK_CYCLES-th clock edge after reset, and then on every TICK_CYCLES edges. The order is bit 0, 1, 2, 3, then back to bit 0.
- R4: Switch bit i goes to 1 and stays there. The rising edge is seen through a two-flop synchronizer. If lamp bit i is lit at the third clock edge that samples the switch high, `win` goes to 1 at that edge.
- R5: A switch that is held on gives no win, including one that was already on when reset was released.
- R6: A rising edge on a switch whose lamp is not lit at the deciding edge has no effect. Rotation continues as in R3.
- R7: Once `win` is 1, it stays 1 and `led_out` is 4'b1111 until reset, whatever the switches do.
- R8: A reset applied in the win state returns the block to the R1 state, and play resumes.
- R9: Turning a switch off (1 to 0) never causes a win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 4 | Player switches, asynchronous, bit i paired with lamp i |
| led_out | output | 4 | Lamp drive: one-hot in play, all ones after a win |
| win | output | 1 | Jackpot flag, latched until reset |

## Verification
The bench builds the block with TICK_CYCLES = 5. With this value the lamp goes fully around the ring many times in a few hundred cycles. It also means a switch edge can be placed so that a chosen lamp is lit at the deciding edge, both to hit it and to miss it. The synchronizer keeps its default depth of two, so the three-edge latency of R4 is the one that is checked. Held switches across reset, falling edges, and switch activity after a win are all reached within a short run.

// File: rtl/jackpot_pkg.sv
package jackpot_pkg;

    localparam int LAMP_COUNT = 4;

    typedef logic [LAMP_COUNT-1:0] lamp_vec_t;

    typedef enum logic {
        GM_PLAY = 1'b0,
        GM_WIN  = 1'b1
    } game_mode_e;

    typedef struct packed {
        game_mode_e mode;
        lamp_vec_t  lit;
    } game_view_t;

    localparam lamp_vec_t LAMP_HOME = lamp_vec_t'(1);
    localparam lamp_vec_t LAMP_ALL  = '1;

    function automatic lamp_vec_t rotate_up(input lamp_vec_t v);
        return {v[LAMP_COUNT-2:0], v[LAMP_COUNT-1]};
    endfunction

    function automatic lamp_vec_t view_to_lamps(input game_view_t g);
        return (g.mode == GM_WIN) ? LAMP_ALL : g.lit;
    endfunction

endpackage

// File: rtl/jp_tick_gen.sv
module jp_tick_gen #(
    parameter int TICK_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/jp_sw_edge.sv
module jp_sw_edge #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] sw_async,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] pipe_q [STAGES];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) pipe_q[0] <= sw_async;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) pipe_q[s] <= pipe_q[s-1];
    end

    always_ff @(posedge clk) last_q <= pipe_q[STAGES-1];

    assign rise = pipe_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/jp_ring.sv
module jp_ring
    import jackpot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output lamp_vec_t lit
);
    always_ff @(posedge clk) begin
        if (rst)       lit <= LAMP_HOME;
        else if (step) lit <= rotate_up(lit);
    end
endmodule

// File: rtl/jp_judge.sv
module jp_judge
    import jackpot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lamp_vec_t  rise,
    input  lamp_vec_t  lit,
    output game_mode_e mode
);
    logic hit;
    assign hit = |(rise & lit);

    always_ff @(posedge clk) begin
        if (rst)                        mode <= GM_PLAY;
        else if (mode == GM_PLAY && hit) mode <= GM_WIN;
    end
endmodule

// File: rtl/jackpot_game.sv
module jackpot_game
    import jackpot_pkg::*;
#(
    parameter int TICK_CYCLES = 10_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LAMP_COUNT-1:0] sw_in,
    output logic [LAMP_COUNT-1:0] led_out,
    output logic                  win
);
    logic       tick;
    lamp_vec_t  sw_rise;
    lamp_vec_t  ring_lit;
    game_mode_e mode;
    game_view_t view;

    jp_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    jp_sw_edge #(.WIDTH(LAMP_COUNT), .STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .sw_async(sw_in),
        .rise    (sw_rise)
    );

    jp_ring u_ring (
        .clk (clk),
        .rst (rst),
        .step(tick && (mode == GM_PLAY)),
        .lit (ring_lit)
    );

    jp_judge u_judge (
        .clk (clk),
        .rst (rst),
        .rise(sw_rise),
        .lit (ring_lit),
        .mode(mode)
    );

    assign view    = '{mode: mode, lit: ring_lit};
    assign led_out = view_to_lamps(view);
    assign win     = (mode == GM_WIN);
endmodule

// File: rtl/jackpot_game_chk.sv
module jackpot_game_chk
    import jackpot_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input lamp_vec_t led_out,
    input logic      win,
    input lamp_vec_t sw_rise
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (led_out == LAMP_HOME && !win));

    // R2
    play_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !win |-> $onehot(led_out));

    // R3
    ring_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!win && !$past(rst)) |-> (led_out == $past(led_out)
                                   || led_out == rotate_up($past(led_out))));

    // R4
    win_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!win && (sw_rise & led_out) == '0) |=> !win);

    // R7
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        win |=> win);

    // R7
    win_lamps_chk: assert property (@(posedge clk) disable iff (rst)
        win |-> (led_out == LAMP_ALL));
endmodule

bind jackpot_game jackpot_game_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .led_out(led_out),
    .win    (win),
    .sw_rise(sw_rise)
);

// File: tb/jackpot_game_tb.sv
module jackpot_game_tb;
    localparam int T = 5;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] sw  = '0;
    logic [N-1:0] led_out;
    logic         win;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    int m_cnt = 0, m_pos = 0;
    bit m_won = 0;

    always #5 clk = ~clk;

    jackpot_game #(.TICK_CYCLES(T)) u_dut (
        .clk(clk), .rst(rst), .sw_in(sw), .led_out(led_out), .win(win)
    );

    function automatic logic [N-1:0] exp_led();
        return m_won ? {N{1'b1}} : (N'(1) << m_pos);
    endfunction

    task automatic check(string req, logic [N-1:0] got_l, logic got_w,
                         logic [N-1:0] exp_l, logic exp_w);
        vectors++;
        if (got_l !== exp_l || got_w !== exp_w) begin
            errors++;
            $display("FAIL %s: led=%b win=%b expected led=%b win=%b at %0t",
                     req, got_l, got_w, exp_l, exp_w, $time);
        end
    endtask

    task automatic cycle();
        logic [N-1:0] rise;
        bit tick;
        @(posedge clk);
        rise = m_s2 & ~m_prev;
        tick = (m_cnt == T - 1);
        if (rst) begin
            m_cnt = 0; m_pos = 0; m_won = 0;
        end else begin
            if (!m_won && tick) m_pos = (m_pos + 1) % N;
            if (rise[(m_pos + N - (!m_won && tick ? 1 : 0)) % N]) m_won = 1;
            m_cnt = tick ? 0 : m_cnt + 1;
        end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = sw;
        @(negedge clk);
        check(cur_req, led_out, win, exp_led(), m_won);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic align();
        while (m_cnt != 0) cycle();
    endtask

    task automatic do_reset(int n);
        rst = 1'b1;
        run(n);
        rst = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        do_reset(4);
        check("R1", led_out, win, 4'b0001, 1'b0);

        cur_req = "R3";
        run(4 * T * 3);

        // R5: switches held on across reset
        cur_req = "R5";
        sw = 4'b1111;
        do_reset(4);
        run(6 * T);
        check("R5", led_out, win, exp_led(), 1'b0);

        // R9: falling edges while in play
        cur_req = "R9";
        sw = 4'b0000;
        run(3 * T);
        check("R9", {3'b0, win}, win, 4'b0000, 1'b0);

        // R6: raise a switch away from the lit lamp
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            align();
            sw[(m_pos + 2) % N] = 1'b1;
            run(T);
            sw = '0;
            run(2);
        end
        check("R6", {3'b0, win}, win, 4'b0000, 1'b0);

        // R4: hit the lit lamp, exact latency
        cur_req = "R4";
        align();
        sw[m_pos] = 1'b1;
        run(2);
        check("R4", {3'b0, win}, win, 4'b0000, 1'b0);
        run(1);
        check("R4", led_out, win, 4'b1111, 1'b1);

        // R7: frozen win whatever the switches do
        cur_req = "R7";
        sw = 4'b0000; run(5);
        sw = 4'b1010; run(5);
        sw = 4'b0101; run(3 * T);
        check("R7", led_out, win, 4'b1111, 1'b1);

        // R8: reset out of win
        cur_req = "R8";
        sw = 4'b0000;
        do_reset(3);
        check("R8", led_out, win, 4'b0001, 1'b0);
        run(3);

        // R4 again on lamp 2
        cur_req = "R4";
        align();
        while (m_pos != 2) begin cycle(); align(); end
        sw[2] = 1'b1;
        run(3);
        check("R4", led_out, win, 4'b1111, 1'b1);
        run(2 * T);

        // R2 / R3 after another reset with no switches
        cur_req = "R2";
        sw = '0;
        do_reset(3);
        run(4 * T);
        check("R3", led_out, win, exp_led(), 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule